// File: doc/BRIEF.md
# PDM Channel Capture Selector

This block drives the bit clock for a set of pulse-density-modulated microphones and captures their data. Two data lines are shared by up to four microphones: on each line one microphone drives its bit in the high half of the clock period and the other in the low half. The block samples both lines at both clock transitions, which yields four microphone slots per clock period. Each of four output channels is steered to one of those slots by a pair of configuration bits, and each channel is gated by its own enable.

Once per bit-clock period the block presents one frame on a valid/ready stream to a downstream decimator: one bit for each channel, in channel order, with disabled channels reading zero. The block is always the clock master. The enables and the slot configuration are plain inputs, held by a register file elsewhere. Software is expected to enable channels contiguously from channel 0, but the block treats each enable bit independently.

The stream is not buffered beyond one frame. `out_valid` stays high until a cycle in which `out_ready` is high. If a new frame is formed while the previous one is still pending, the new frame replaces the old one, so the decimator always sees the freshest bits. The producer cannot be stalled, because the microphones cannot be stalled.

Top module: `pdm_slot_capture`

## Requirements
- R1: `pdm_clk_o` is held low in every cycle that follows a cycle with `chan_en` all zero.
- R2: While any enable bit is set, `pdm_clk_o` toggles every `HALF_PERIOD` system clock cycles, and its first transition after enabling is a rise.
- R3: Bit 2n+16 of `slot_cfg` selects the data line for channel n: 0 selects `pdm_data_i[0]` and 1 selects `pdm_data_i[1]`.
- R4: Bit 2n of `slot_cfg` selects the slot edge for channel n: 0 selects the value sampled at the rise of `pdm_clk_o` and 1 selects the value sampled at its fall.
- R5: A frame is issued at each rise of `pdm_clk_o` that follows a fall, with `out_valid` high in the same cycle as the rise. It carries the fall sample from the preceding fall and the rise sample taken at that rise. The first rise after enabling issues no frame.
- R6: Bit n of `out_data` is 0 in every frame when `chan_en[n]` is 0, whatever the line data.
- R7: Channels configured to the same line and edge carry identical bits, and no error is raised.
- R8: `out_valid` stays high with `out_data` unchanged until a cycle with `out_ready` high, unless a newer frame replaces the pending one. It drops in the cycle after the handshake.
- R9: After reset, `out_valid` is 0, `out_data` is 0 and `pdm_clk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | NCH | Per-channel enable; bit n enables channel n |
| slot_cfg | input | 32 | Edge select for channel n at bit 2n, line select for channel n at bit 2n+16 |
| pdm_data_i | input | 2 | Microphone data lines, asynchronous to clk |
| pdm_clk_o | output | 1 | Generated PDM bit clock |
| out_data | output | NCH | One bit per channel for the current frame |
| out_valid | output | 1 | Frame available |
| out_ready | input | 1 | Downstream accepts the frame |

## Verification
The bench drives a distinct value on each line before each clock transition, so that a design that swaps the rise and fall slots, or decodes the select bits at the wrong positions, returns a wrong pattern for some of the 16 line combinations. It checks that the first rise after enabling issues no frame; a design that lacks this would emit a frame built from a fall sample never taken. It stalls the stream across two frames to show that the pending frame is held and then replaced rather than dropped early or frozen. It also checks that disabled channels read zero and that the clock parks low when every channel is off.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;
  localparam int NUM_LINES      = 2;
  localparam int NUM_SLOTS      = 2 * NUM_LINES;
  localparam int EDGE_SEL_BASE  = 0;
  localparam int LINE_SEL_BASE  = 16;
  localparam int SEL_STRIDE     = 2;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  // slot index = line * 2 + edge
  function automatic logic [1:0] slot_index(input logic line_sel, input edge_sel_e edge_sel);
    return {line_sel, logic'(edge_sel)};
  endfunction
endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen #(
  parameter int HALF_PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pdm_clk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_evt = wrap && !pdm_clk;
  assign fall_evt = wrap &&  pdm_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pdm_clk <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      pdm_clk <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      pdm_clk <= ~pdm_clk;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pdm_clk); // R1

  AST_RISE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pdm_clk && !$past(pdm_clk)) |-> ($past(cnt) == LAST && $past(run))); // R2
endmodule

// File: rtl/pdm_line_capture.sv
module pdm_line_capture
  import pdm_cap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] data_i,
  input  logic                 fall_evt,
  output logic [NUM_LINES-1:0] rise_bits,
  output logic [NUM_LINES-1:0] fall_bits
);
  logic [NUM_LINES-1:0] sync_a;
  logic [NUM_LINES-1:0] sync_b;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_a[g]    <= 1'b0;
        sync_b[g]    <= 1'b0;
        fall_bits[g] <= 1'b0;
      end else begin
        sync_a[g] <= data_i[g];
        sync_b[g] <= sync_a[g];
        if (fall_evt) fall_bits[g] <= sync_b[g];
      end
    end
  end

  // rise slot is taken straight from the synchronizer on the rise event
  assign rise_bits = sync_b;

  AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(fall_bits)); // R5
endmodule

// File: rtl/pdm_chan_select.sv
module pdm_chan_select
  import pdm_cap_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NUM_SLOTS-1:0] slots,
  input  logic [31:0]          cfg,
  input  logic [NCH-1:0]       en,
  output logic [NCH-1:0]       bits
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic      line_sel;
    edge_sel_e edge_sel;
    logic [1:0] idx;
    assign line_sel = cfg[LINE_SEL_BASE + SEL_STRIDE*n];
    assign edge_sel = edge_sel_e'(cfg[EDGE_SEL_BASE + SEL_STRIDE*n]);
    assign idx      = slot_index(line_sel, edge_sel);
    assign bits[n]  = en[n] & slots[idx];
  end
endmodule

// File: rtl/pdm_slot_capture.sv
module pdm_slot_capture
  import pdm_cap_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int HALF_PERIOD = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       chan_en,
  input  logic [31:0]          slot_cfg,
  input  logic [NUM_LINES-1:0] pdm_data_i,
  output logic                 pdm_clk_o,
  output logic [NCH-1:0]       out_data,
  output logic                 out_valid,
  input  logic                 out_ready
);
  logic                 run;
  logic                 rise_evt;
  logic                 fall_evt;
  logic                 fall_seen;
  logic [NUM_LINES-1:0] rise_bits;
  logic [NUM_LINES-1:0] fall_bits;
  logic [NUM_SLOTS-1:0] slots;
  logic [NCH-1:0]       frame_bits;
  logic                 issue;

  assign run = |chan_en;

  pdm_clkgen #(.HALF_PERIOD(HALF_PERIOD)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pdm_clk  (pdm_clk_o),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  pdm_line_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_i    (pdm_data_i),
    .fall_evt  (fall_evt),
    .rise_bits (rise_bits),
    .fall_bits (fall_bits)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_slots
    assign slots[2*l + 0] = rise_bits[l];
    assign slots[2*l + 1] = fall_bits[l];
  end

  pdm_chan_select #(.NCH(NCH)) u_select (
    .slots (slots),
    .cfg   (slot_cfg),
    .en    (chan_en),
    .bits  (frame_bits)
  );

  assign issue = rise_evt && fall_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_seen <= 1'b0;
    end else if (!run) begin
      fall_seen <= 1'b0;
    end else if (fall_evt) begin
      fall_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (issue) begin
      out_valid <= 1'b1;
      out_data  <= frame_bits;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R8

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !issue) |=> $stable(out_data)); // R8

  AST_FRAME_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (pdm_clk_o && !$past(pdm_clk_o))); // R5
endmodule

// File: tb/pdm_slot_capture_test.sv
module pdm_slot_capture_test;
  localparam int NCH  = 4;
  localparam int HALF = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] chan_en = '0;
  logic [31:0]    slot_cfg = '0;
  logic [1:0]     pdm_data_i = '0;
  logic           pdm_clk_o;
  logic [NCH-1:0] out_data;
  logic           out_valid;
  logic           out_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pdm_slot_capture #(.NCH(NCH), .HALF_PERIOD(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .slot_cfg(slot_cfg),
    .pdm_data_i(pdm_data_i), .pdm_clk_o(pdm_clk_o), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input logic [3:0] edge_s, input logic [3:0] line_s);
    logic [31:0] c = '0;
    for (int n = 0; n < 4; n++) begin
      c[2*n]      = edge_s[n];
      c[2*n + 16] = line_s[n];
    end
    return c;
  endfunction

  function automatic logic [3:0] expect_bits(input logic [1:0] f, input logic [1:0] r);
    logic [3:0] e;
    for (int n = 0; n < 4; n++) begin
      logic ln, ed;
      ln = slot_cfg[2*n + 16];
      ed = slot_cfg[2*n];
      e[n] = chan_en[n] & (ed ? f[ln] : r[ln]);
    end
    return e;
  endfunction

  task automatic wait_rise();
    logic prev;
    do begin
      prev = pdm_clk_o;
      @(negedge clk);
    end while (!(pdm_clk_o && !prev));
  endtask

  task automatic wait_fall();
    logic prev;
    do begin
      prev = pdm_clk_o;
      @(negedge clk);
    end while (!(!pdm_clk_o && prev));
  endtask

  // called just after an observed rise; ends just after the next rise
  task automatic do_frame(input logic [1:0] f, input logic [1:0] r, input string req);
    logic [3:0] e;
    pdm_data_i = f;
    wait_fall();
    pdm_data_i = r;
    wait_rise();
    e = expect_bits(f, r);
    check(out_valid == 1'b1, {req, " valid"}, 32'(out_valid), 32'd1);
    check(out_data == e, {req, " data"}, 32'(out_data), 32'(e));
  endtask

  task automatic t_reset();
    check(pdm_clk_o == 1'b0, "R9 clk", 32'(pdm_clk_o), 0);
    check(out_valid == 1'b0, "R9 valid", 32'(out_valid), 0);
    check(out_data == '0, "R9 data", 32'(out_data), 0);
    repeat (5) @(negedge clk);
    check(pdm_clk_o == 1'b0, "R1 idle", 32'(pdm_clk_o), 0);
  endtask

  task automatic t_start_period();
    int cnt;
    slot_cfg = mk_cfg(4'b0000, 4'b0000);
    chan_en  = 4'b0001;
    wait_rise();
    check(out_valid == 1'b0, "R5 no frame on first rise", 32'(out_valid), 0);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (pdm_clk_o);
    check(cnt == HALF, "R2 high half", cnt, HALF);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!pdm_clk_o);
    check(cnt == HALF, "R2 low half", cnt, HALF);
    check(out_valid == 1'b1, "R5 frame after fall", 32'(out_valid), 1);
  endtask

  task automatic t_line_edge();
    chan_en  = 4'b1111;
    slot_cfg = mk_cfg(4'b1010, 4'b1100);
    for (int p = 0; p < 16; p++)
      do_frame(2'(p >> 2), 2'(p), "R3 R4 R5 map A");
  endtask

  task automatic t_swapped();
    slot_cfg = mk_cfg(4'b0101, 4'b0011);
    do_frame(2'b01, 2'b10, "R3 R4 map B");
    do_frame(2'b10, 2'b01, "R3 R4 map B");
    do_frame(2'b11, 2'b00, "R3 R4 map B");
  endtask

  task automatic t_partial_en();
    chan_en  = 4'b0011;
    slot_cfg = mk_cfg(4'b1010, 4'b1100);
    do_frame(2'b11, 2'b11, "R6 disabled zero");
    check(out_data[3:2] == 2'b00, "R6 upper", 32'(out_data[3:2]), 0);
    chan_en = 4'b1111;
    do_frame(2'b11, 2'b11, "R6 re-enabled");
  endtask

  task automatic t_duplicate();
    slot_cfg = mk_cfg(4'b1111, 4'b1111);
    do_frame(2'b10, 2'b01, "R7 shared slot");
    check(out_data == 4'b1111, "R7 all ones", 32'(out_data), 32'hf);
    do_frame(2'b01, 2'b10, "R7 shared slot");
    check(out_data == 4'b0000, "R7 all zero", 32'(out_data), 0);
  endtask

  task automatic t_backpressure();
    logic [3:0] first;
    slot_cfg = mk_cfg(4'b0000, 4'b0101);
    out_ready = 1'b0;
    do_frame(2'b00, 2'b01, "R8 first");
    first = out_data;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R8 held valid", 32'(out_valid), 1);
    check(out_data == first, "R8 held data", 32'(out_data), 32'(first));
    do_frame(2'b00, 2'b10, "R8 replaced");
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 drop after handshake", 32'(out_valid), 0);
  endtask

  task automatic t_disable();
    chan_en = 4'b0000;
    @(negedge clk);
    @(negedge clk);
    check(pdm_clk_o == 1'b0, "R1 parked", 32'(pdm_clk_o), 0);
    repeat (2 * HALF + 2) @(negedge clk);
    check(pdm_clk_o == 1'b0, "R1 stays low", 32'(pdm_clk_o), 0);
    check(out_valid == 1'b0, "R1 no frames", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_period();
    t_line_edge();
    t_swapped();
    t_partial_en();
    t_duplicate();
    t_backpressure();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule